// File: doc/BRIEF.md
# Rank-Counter LRU Victim Selector

This block tracks how recently each way of one cache set has been used and names the way to evict on a miss. Each way holds a small rank counter. Rank 0 means most recently used and rank WAYS-1 means least recently used. Across all ways the ranks always form a permutation of 0..WAYS-1.

The surrounding cache controller decides whether a lookup hit or missed. On a hit it pulses `hit_vld` with the way that hit. On a miss it pulses `miss_vld`. The block updates every rank at the next clock edge. For a miss it also reports the evicted way one cycle after the strobe, on `victim_way` qualified by `victim_vld`. The current ranks are brought out on `ranks_o` for checking.

A parameter chooses how the victim is found. The match variant compares each rank with the constant WAYS-1, which relies on the permutation property. The scan variant is a general maximum search that does not.

Top module: `lru_rank_tracker`

## Requirements
- R1: After reset, way w holds rank w. Way w's rank sits in `ranks_o[w*IDX_W +: IDX_W]`, where IDX_W = log2(WAYS).
- R2: One cycle after a hit strobe, the rank of the hit way is 0.
- R3: On a hit, every other way whose rank was below the hit way's previous rank gains 1.
- R4: On a hit, every way whose rank was above the hit way's previous rank keeps its value.
- R5: One cycle after a miss strobe, `victim_vld` is 1 and `victim_way` names the way that held the largest rank (WAYS-1) before the update.
- R6: On a miss, the victim's rank becomes 0 and every other rank gains 1.
- R7: When both strobes are high in one cycle, only the hit update is applied, and `victim_vld` is 0 in the next cycle.
- R8: In a cycle with no strobe, all ranks hold and `victim_vld` is 0 in the next cycle.
- R9: At every clock the ranks are a permutation of 0..WAYS-1.
- R10: A hit on the way whose rank is already 0 leaves all ranks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_vld | input | 1 | A lookup hit this cycle |
| hit_way | input | IDX_W | Way that hit |
| miss_vld | input | 1 | A lookup missed; a victim is requested |
| victim_vld | output | 1 | `victim_way` is valid (one cycle after a miss) |
| victim_way | output | IDX_W | Way chosen for eviction |
| ranks_o | output | WAYS*IDX_W | All rank counters, way 0 in the low bits |

## Verification
The bench targets these corner cases:

- **A run of misses with no hits.** The victims must then rotate through the ways in descending order. A selector that picked the smallest rank, or failed to clear the victim, would repeat one way or evict the newest line.
- **A hit on the rank-0 way.** This must change nothing. A design comparing with "less than or equal" would bump the hit way itself and break the permutation.
- **A hit on the oldest way.** Every other way must then age.
- **Both strobes in the same cycle.** A design that let the miss win would raise `victim_vld` and age every way.

A long random mix is compared against a behavioural model on every cycle.

// File: rtl/lru_pkg.sv
package lru_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_HIT  = 2'd1,
      OP_MISS = 2'd2
   } lru_op_e;

endpackage

// File: rtl/lru_age_cell.sv
module lru_age_cell
   import lru_pkg::*;
#(
   parameter int unsigned IDX_W = 2,
   parameter logic [IDX_W-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lru_op_e          op,
   input  logic             sel,
   input  logic [IDX_W-1:0] ref_rank,
   output logic [IDX_W-1:0] rank_q
);

   logic [IDX_W-1:0] rank_d;

   always_comb begin
      rank_d = rank_q;
      unique case (op)
         OP_HIT: begin
            if (sel)
               rank_d = '0;
            else if (rank_q < ref_rank)
               rank_d = rank_q + IDX_W'(1);
         end
         OP_MISS: begin
            if (sel)
               rank_d = '0;
            else
               rank_d = rank_q + IDX_W'(1);
         end
         default: rank_d = rank_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rank_q <= INIT;
      else
         rank_q <= rank_d;
   end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
   parameter int unsigned WAYS       = 4,
   parameter bit          RANK_MATCH = 1'b1,
   localparam int unsigned IDX_W     = $clog2(WAYS)
) (
   input  logic [WAYS*IDX_W-1:0] ranks,
   output logic [IDX_W-1:0]      pick_way
);

   localparam logic [IDX_W-1:0] TOP_RANK = IDX_W'(WAYS - 1);

   generate
      if (RANK_MATCH) begin : g_match
         always_comb begin
            pick_way = '0;
            for (int w = 0; w < WAYS; w++) begin
               if (ranks[w*IDX_W +: IDX_W] == TOP_RANK)
                  pick_way = IDX_W'(w);
            end
         end
      end else begin : g_scan
         logic [IDX_W-1:0] best_rank;
         always_comb begin
            pick_way  = '0;
            best_rank = ranks[IDX_W-1:0];
            for (int w = 1; w < WAYS; w++) begin
               if (ranks[w*IDX_W +: IDX_W] > best_rank) begin
                  best_rank = ranks[w*IDX_W +: IDX_W];
                  pick_way  = IDX_W'(w);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lru_rank_tracker.sv
module lru_rank_tracker
   import lru_pkg::*;
#(
   parameter int unsigned WAYS       = 4,
   parameter bit          RANK_MATCH = 1'b1,
   localparam int unsigned IDX_W     = $clog2(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hit_vld,
   input  logic [IDX_W-1:0]      hit_way,
   input  logic                  miss_vld,
   output logic                  victim_vld,
   output logic [IDX_W-1:0]      victim_way,
   output logic [WAYS*IDX_W-1:0] ranks_o
);

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("lru_rank_tracker: WAYS must be a power of two and at least 2");
      end
   endgenerate

   lru_op_e          op;
   logic [IDX_W-1:0] pick_way;
   logic [IDX_W-1:0] hit_rank;
   logic [IDX_W-1:0] target_way;

   always_comb begin
      if (hit_vld)
         op = OP_HIT;
      else if (miss_vld)
         op = OP_MISS;
      else
         op = OP_IDLE;
   end

   assign hit_rank   = ranks_o[hit_way*IDX_W +: IDX_W];
   assign target_way = (op == OP_HIT) ? hit_way : pick_way;

   lru_victim_pick #(
      .WAYS       (WAYS),
      .RANK_MATCH (RANK_MATCH)
   ) pick_i (
      .ranks    (ranks_o),
      .pick_way (pick_way)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      lru_age_cell #(
         .IDX_W (IDX_W),
         .INIT  (IDX_W'(w))
      ) cell_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .op       (op),
         .sel      (target_way == IDX_W'(w)),
         .ref_rank (hit_rank),
         .rank_q   (ranks_o[w*IDX_W +: IDX_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_vld <= 1'b0;
         victim_way <= '0;
      end else begin
         victim_vld <= (op == OP_MISS);
         if (op == OP_MISS)
            victim_way <= pick_way;
      end
   end

endmodule

// File: rtl/lru_rank_tracker_chk.sv
module lru_rank_tracker_chk #(
   parameter int unsigned WAYS   = 4,
   localparam int unsigned IDX_W = $clog2(WAYS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  hit_vld,
   input logic [IDX_W-1:0]      hit_way,
   input logic                  miss_vld,
   input logic                  victim_vld,
   input logic [IDX_W-1:0]      victim_way,
   input logic [WAYS*IDX_W-1:0] ranks_o
);

   function automatic logic [IDX_W-1:0] rank_of(logic [WAYS*IDX_W-1:0] v,
                                                logic [IDX_W-1:0] idx);
      return v[idx*IDX_W +: IDX_W];
   endfunction

   logic [WAYS-1:0] seen;
   always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++)
         seen[ranks_o[w*IDX_W +: IDX_W]] = 1'b1;
   end

   // R9
   permutation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seen) == WAYS);

   // R2
   hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld |=> rank_of(ranks_o, $past(hit_way)) == '0);

   // R5
   miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_vld && !hit_vld) |=> victim_vld);

   // R5
   victim_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> rank_of($past(ranks_o), victim_way) == IDX_W'(WAYS - 1));

   // R6
   victim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> rank_of(ranks_o, victim_way) == '0);

   // R7
   hit_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld |=> !victim_vld);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_vld && !miss_vld) |=> ($stable(ranks_o) && !victim_vld));

endmodule

bind lru_rank_tracker lru_rank_tracker_chk #(.WAYS(WAYS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .hit_vld    (hit_vld),
   .hit_way    (hit_way),
   .miss_vld   (miss_vld),
   .victim_vld (victim_vld),
   .victim_way (victim_way),
   .ranks_o    (ranks_o)
);

// File: tb/lru_rank_tracker_tb_top.sv
module lru_rank_tracker_tb_top;

   localparam int WAYS  = 4;
   localparam int IDX_W = $clog2(WAYS);

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  hit_vld = 1'b0;
   logic [IDX_W-1:0]      hit_way = '0;
   logic                  miss_vld = 1'b0;
   logic                  victim_vld;
   logic [IDX_W-1:0]      victim_way;
   logic [WAYS*IDX_W-1:0] ranks_o;

   int total = 0;
   int bad   = 0;
   int mdl[WAYS];
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lru_rank_tracker #(.WAYS(WAYS)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_vld    (hit_vld),
      .hit_way    (hit_way),
      .miss_vld   (miss_vld),
      .victim_vld (victim_vld),
      .victim_way (victim_way),
      .ranks_o    (ranks_o)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int obs(int w);
      return int'(ranks_o[w*IDX_W +: IDX_W]);
   endfunction

   task automatic check_perm();
      int cnt[WAYS];
      int ok = 1;
      for (int v = 0; v < WAYS; v++) cnt[v] = 0;
      for (int w = 0; w < WAYS; w++) cnt[obs(w)]++;
      for (int v = 0; v < WAYS; v++) if (cnt[v] != 1) ok = 0;
      check("R9 permutation", ok, 1);
   endtask

   // one cycle: drive at negedge, update model, compare at next negedge
   task automatic step(bit h, int hw, bit m);
      int prev[WAYS];
      int exp_victim = 0;
      int ref_r;
      bit exp_vld;
      for (int w = 0; w < WAYS; w++) prev[w] = mdl[w];
      hit_vld  = h;
      hit_way  = IDX_W'(hw);
      miss_vld = m;
      exp_vld  = 1'b0;
      if (h) begin
         ref_r = prev[hw];
         for (int w = 0; w < WAYS; w++)
            if (w == hw) mdl[w] = 0;
            else if (prev[w] < ref_r) mdl[w] = prev[w] + 1;
      end else if (m) begin
         for (int w = 0; w < WAYS; w++) if (prev[w] == WAYS - 1) exp_victim = w;
         for (int w = 0; w < WAYS; w++) mdl[w] = (w == exp_victim) ? 0 : prev[w] + 1;
         exp_vld = 1'b1;
      end
      @(negedge clk);
      hit_vld  = 1'b0;
      miss_vld = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (h && m)                 check("R7 hit-only update", obs(w), mdl[w]);
         else if (h && prev[hw] == 0) check("R10 hit on newest", obs(w), mdl[w]);
         else if (h && w == hw)       check("R2 hit way cleared", obs(w), mdl[w]);
         else if (h && prev[w] < prev[hw]) check("R3 younger aged", obs(w), mdl[w]);
         else if (h)                  check("R4 older held", obs(w), mdl[w]);
         else if (m)                  check("R6 miss update", obs(w), mdl[w]);
         else                         check("R8 idle hold", obs(w), mdl[w]);
      end
      if (h && m)      check("R7 no victim", int'(victim_vld), 0);
      else if (m) begin
         check("R5 victim valid", int'(victim_vld), 1);
         check("R5 victim way", int'(victim_way), exp_victim);
      end else if (!h) check("R8 no victim", int'(victim_vld), int'(exp_vld));
      check_perm();
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      for (int w = 0; w < WAYS; w++) mdl[w] = w;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int w = 0; w < WAYS; w++) check("R1 reset rank", obs(w), w);
      check("R1 reset victim_vld", int'(victim_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(0, 0, 0);                       // R8
      for (int i = 0; i < WAYS + 1; i++)   // R5/R6: rotating victims
         step(0, 0, 1);
      for (int w = 0; w < WAYS; w++)       // R10: hit the rank-0 way
         if (mdl[w] == 0) step(1, w, 0);
      for (int w = 0; w < WAYS; w++)       // R3: hit the oldest way
         if (mdl[w] == WAYS - 1) step(1, w, 0);
      step(1, 1, 0);
      step(1, 2, 1);                       // R7
      step(0, 0, 1);
      step(0, 0, 0);
      for (int i = 0; i < 400; i++) begin
         int r = $urandom_range(0, 9);
         step(r < 5, $urandom_range(0, WAYS - 1), r >= 4 && r < 8);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule